// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Writer

This block loads a value into the hidden tuning registers of an analog USB PHY. Those registers have no parallel access. They are reached one bit at a time through a single control word that the PHY watches. A write request carries an 8-bit base address, up to 8 data bits, a bit count and a port index. The block sends the data least significant bit first. For each bit it places the target address and the data bit in the control word, then raises and lowers the strobe bit that belongs to the selected port. The address goes up by one for each bit.

Every phase (setup, strobe high, strobe low) is held for a programmable number of clock cycles, so a slow analog side can be served. A mode input selects the newer register layout, in which the whole control word is zeroed once before the first bit. There is a shortcut request that writes the 2-bit squelch-detect control at tuning address 0x3C: the value 0 turns detection on and the value 2 turns it off. The block raises busy while a write is in flight and pulses done when it finishes.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset busy and done are low and ctlWord equals the reset value 32'h5A00_0022.
- R2: The address of the bit being sent sits in ctlWord[15:8], the data bit in ctlWord[7] and the strobe for port n in ctlWord[2n]. When clearFirst is low at acceptance, every other bit keeps its previous value, and the address and data fields keep the values of the last bit sent.
- R3: Bit i of the data is sent LSB first at address base+i, modulo 256, with one strobe pulse per bit.
- R4: For each bit the address and data are set while the strobe is low. The strobe then goes high and then low again, and each phase lasts holdCycles cycles (0 counts as 1). For a length L>0 and a hold H, done is high in the (2+3·H·L)-th cycle after the accepting edge.
- R5: With clearFirst high at acceptance and L>0, ctlWord is all zero in the cycle after acceptance, before any field is set.
- R6: busy is high from the cycle after acceptance through the done cycle. done is a single-cycle pulse. Requests made while busy are ignored.
- R7: A length of 0 completes with done in the first cycle after acceptance and leaves ctlWord unchanged. A length above 8 is sent as 8 bits.
- R8: squelchReq writes 2 bits at address 0x3C with the value 0 when squelchOn is 1 and the value 2 when squelchOn is 0. When startReq and squelchReq arrive together, startReq wins.
- R9: Only the selected port's strobe ever rises, at most one strobe is high at a time, and no strobe is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a general write (taken when idle) |
| reqAddr | input | 8 | Base tuning address |
| reqData | input | 8 | Data to send, LSB first |
| reqLen | input | 4 | Number of bits, 0 to 8 (higher values are treated as 8) |
| reqPort | input | 2 | Target port index |
| clearFirst | input | 1 | Newer-layout mode: zero the word before the first bit |
| holdCycles | input | 4 | Cycles per phase, 0 is treated as 1 |
| squelchReq | input | 1 | Request the squelch-detect write |
| squelchOn | input | 1 | 1 enables squelch detection, 0 disables it |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| ctlWord | output | 32 | Side-band control word read by the PHY |

## Verification
A corrupted bit counter or shift register shows up at the next strobe rise, as a wrong address field or a wrong data bit. It also shows up in the total number of pulses once done arrives. A phase counter that is off by one moves the done cycle away from 2+3·H·L and changes the measured strobe-high width within one bit time. A port index or clear flag latched wrongly shows up as a strobe on another port, or as surviving upper bits in the final word, no later than the first phase.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } ptwState_e;

  // one-cycle commands from sequencer to datapath
  typedef struct packed {
    logic load;
    logic clearWord;
    logic setBit;
    logic strobeOn;
    logic strobeOff;
    logic nextBit;
  } ptwCmd_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W = 4,
  parameter int PORT_W = 2,
  parameter int HOLD_W = 4,
  parameter int ADDR_LSB = 8,
  parameter int DATA_BIT = 7,
  parameter logic [WORD_W-1:0] WORD_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptwCmd_t           cmd,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [PORT_W-1:0] inPort,
  input  logic [HOLD_W-1:0] inHold,
  output logic [HOLD_W-1:0] holdLat,
  output logic              allSent,
  output logic [WORD_W-1:0] ctlWord
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W);

  logic [ADDR_W-1:0] baseAddr;
  logic [DATA_W-1:0] shData;
  logic [LEN_W-1:0]  lenLat;
  logic [LEN_W-1:0]  bitIdx;
  logic [PORT_W-1:0] portLat;
  logic [IDX_W-1:0]  strbIdx;

  assign strbIdx = IDX_W'({portLat, 1'b0});
  assign allSent = (bitIdx == lenLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      shData   <= '0;
      lenLat   <= '0;
      bitIdx   <= '0;
      portLat  <= '0;
      holdLat  <= HOLD_W'(1);
      ctlWord  <= WORD_RESET;
    end else begin
      if (cmd.load) begin
        baseAddr <= inAddr;
        shData   <= inData;
        lenLat   <= (inLen > MAX_LEN) ? MAX_LEN : inLen;
        portLat  <= inPort;
        holdLat  <= (inHold == '0) ? HOLD_W'(1) : inHold;
        bitIdx   <= '0;
      end
      if (cmd.clearWord) begin
        ctlWord <= '0;
      end
      if (cmd.setBit) begin
        ctlWord[ADDR_LSB +: ADDR_W] <= baseAddr + ADDR_W'(bitIdx);
        ctlWord[DATA_BIT]           <= shData[0];
        ctlWord[strbIdx]            <= 1'b0;
      end
      if (cmd.strobeOn) begin
        ctlWord[strbIdx] <= 1'b1;
      end
      if (cmd.strobeOff) begin
        ctlWord[strbIdx] <= 1'b0;
      end
      if (cmd.nextBit) begin
        shData <= shData >> 1;
        bitIdx <= bitIdx + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic              emptyReq,
  input  logic              clearFirst,
  input  logic [HOLD_W-1:0] holdLat,
  input  logic              allSent,
  output ptwCmd_t           cmd,
  output logic              busy,
  output logic              done
);

  ptwState_e         state, nextState;
  logic [HOLD_W-1:0] cnt, nextCnt;
  logic [HOLD_W-1:0] holdLast;

  assign holdLast = holdLat - HOLD_W'(1);

  always_comb begin
    cmd       = '0;
    nextState = state;
    nextCnt   = cnt;
    case (state)
      ST_IDLE: begin
        if (go) begin
          cmd.load = 1'b1;
          if (emptyReq) begin
            nextState = ST_DONE;
          end else begin
            cmd.clearWord = clearFirst;
            nextState     = ST_PREP;
          end
        end
      end
      ST_PREP: begin
        cmd.setBit = 1'b1;
        nextCnt    = holdLast;
        nextState  = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          cmd.strobeOn = 1'b1;
          nextCnt      = holdLast;
          nextState    = ST_HIGH;
        end else begin
          nextCnt = cnt - HOLD_W'(1);
        end
      end
      ST_HIGH: begin
        if (cnt == '0) begin
          cmd.strobeOff = 1'b1;
          cmd.nextBit   = 1'b1;
          nextCnt       = holdLast;
          nextState     = ST_LOW;
        end else begin
          nextCnt = cnt - HOLD_W'(1);
        end
      end
      ST_LOW: begin
        if (cnt == '0) begin
          if (allSent) begin
            nextState = ST_DONE;
          end else begin
            cmd.setBit = 1'b1;
            nextCnt    = holdLast;
            nextState  = ST_SETUP;
          end
        end else begin
          nextCnt = cnt - HOLD_W'(1);
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import ptw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_PORTS = 4,
  parameter int HOLD_W = 4,
  parameter int ADDR_LSB = 8,
  parameter int DATA_BIT = 7,
  parameter logic [WORD_W-1:0] WORD_RESET = 32'h5A00_0022,
  parameter logic [ADDR_W-1:0] SQ_ADDR = 8'h3C,
  localparam int LEN_W = $clog2(DATA_W + 1),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [PORT_W-1:0] reqPort,
  input  logic              clearFirst,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic              squelchReq,
  input  logic              squelchOn,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ctlWord
);

  ptwCmd_t           cmd;
  logic              useSq;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [LEN_W-1:0]  selLen;
  logic [HOLD_W-1:0] holdLat;
  logic              allSent;

  // squelch shortcut: 2 bits, 0 = detect on, 2 = detect off
  assign useSq   = squelchReq & ~startReq;
  assign selAddr = useSq ? SQ_ADDR : reqAddr;
  assign selData = useSq ? (squelchOn ? '0 : DATA_W'(2)) : reqData;
  assign selLen  = useSq ? LEN_W'(2) : reqLen;

  ptw_control #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .go        (startReq | squelchReq),
    .emptyReq  (selLen == '0),
    .clearFirst(clearFirst),
    .holdLat   (holdLat),
    .allSent   (allSent),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done)
  );

  ptw_datapath #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .PORT_W    (PORT_W),
    .HOLD_W    (HOLD_W),
    .ADDR_LSB  (ADDR_LSB),
    .DATA_BIT  (DATA_BIT),
    .WORD_RESET(WORD_RESET)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .inAddr (selAddr),
    .inData (selData),
    .inLen  (selLen),
    .inPort (reqPort),
    .inHold (holdCycles),
    .holdLat(holdLat),
    .allSent(allSent),
    .ctlWord(ctlWord)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_LSB = 8,
  parameter int DATA_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              squelchReq,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] ctlWord
);

  logic [NUM_PORTS-1:0] strb;
  logic [ADDR_W:0]      fieldNow;
  logic                 unusedWord;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_strb
    assign strb[g] = ctlWord[2*g];
  end

  assign fieldNow   = {ctlWord[ADDR_LSB +: ADDR_W], ctlWord[DATA_BIT]};
  assign unusedWord = ^ctlWord;

  // R6: done only inside a busy window, and a single cycle long
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (startReq || squelchReq)) |=> busy);

  // R9: at most one strobe, never while idle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb != '0) |-> busy);

  // R4: fields settle before the strobe rises and hold while it is high
  a_r4_setup_first: assert property (@(posedge clk) disable iff (!rstN)
    ((strb != '0) && ($past(strb) == '0)) |-> $stable(fieldNow));
  a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    ((strb != '0) && ($past(strb) != '0)) |-> $stable(fieldNow));

endmodule

bind phy_tune_writer ptw_checker #(
  .WORD_W   (WORD_W),
  .ADDR_W   (ADDR_W),
  .NUM_PORTS(NUM_PORTS),
  .ADDR_LSB (ADDR_LSB),
  .DATA_BIT (DATA_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .squelchReq(squelchReq),
  .busy      (busy),
  .done      (done),
  .ctlWord   (ctlWord)
);

// File: tb/phy_tune_writer_tb.sv
`timescale 1ns/1ps
module phy_tune_writer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic [3:0]  reqLen = '0;
  logic [1:0]  reqPort = '0;
  logic        clearFirst = 1'b0;
  logic [3:0]  holdCycles = '0;
  logic        squelchReq = 1'b0;
  logic        squelchOn = 1'b0;
  logic        busy, done;
  logic [31:0] ctlWord;

  always #4 clk = ~clk;

  phy_tune_writer u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqAddr(reqAddr),
    .reqData(reqData), .reqLen(reqLen), .reqPort(reqPort),
    .clearFirst(clearFirst), .holdCycles(holdCycles),
    .squelchReq(squelchReq), .squelchOn(squelchOn),
    .busy(busy), .done(done), .ctlWord(ctlWord)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] expWord = 32'h5A00_0022;

  // monitor of the PHY side: captures a bit on each strobe rise
  logic [31:0] prevWord;
  int          monPort, monHold, pulseCnt, hiRun;
  logic [7:0]  monBase, capVal;
  bit          orderBad, addrBad, widthBad, strayBad;

  always @(negedge clk) begin
    if (!rstN) begin
      prevWord = ctlWord;
    end else begin
      for (int q = 0; q < 4; q++) begin
        if (q != monPort && ctlWord[2*q]) strayBad = 1;
      end
      if (ctlWord[2*monPort] && !prevWord[2*monPort]) begin
        if (ctlWord[15:7] != prevWord[15:7]) orderBad = 1;
        if (ctlWord[15:8] != 8'(monBase + pulseCnt)) addrBad = 1;
        if (pulseCnt < 8) capVal[pulseCnt] = ctlWord[7];
        pulseCnt++;
        hiRun = 1;
      end else if (ctlWord[2*monPort] && prevWord[2*monPort]) begin
        hiRun++;
      end else if (!ctlWord[2*monPort] && prevWord[2*monPort]) begin
        if (hiRun != monHold) widthBad = 1;
      end
      prevWord = ctlWord;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; sq selects squelch request, both raises start and squelch together,
  // inject drives a conflicting start while busy
  task automatic runWrite(input logic [7:0] a, input logic [7:0] d, input int len,
                          input int port, input bit clr, input int hold,
                          input bit sq, input bit sqOn, input bit both,
                          input bit inject);
    int le, he, cyc, expCyc;
    logic [7:0] ea, ed;
    logic [7:0] mask;
    ea = sq ? 8'h3C : a;
    ed = sq ? (sqOn ? 8'h00 : 8'h02) : d;
    le = sq ? 2 : ((len > 8) ? 8 : len);
    he = (hold == 0) ? 1 : hold;
    expCyc = (le == 0) ? 1 : 2 + 3 * he * le;
    mask = (le >= 8) ? 8'hFF : 8'((1 << le) - 1);
    @(negedge clk);
    monPort = port; monHold = he; monBase = ea; pulseCnt = 0; hiRun = 0;
    capVal = '0; orderBad = 0; addrBad = 0; widthBad = 0; strayBad = 0;
    reqAddr = a; reqData = d; reqLen = 4'(len); reqPort = 2'(port);
    clearFirst = clr; holdCycles = 4'(hold);
    startReq = !sq || both; squelchReq = sq || both; squelchOn = sqOn;
    @(negedge clk);
    startReq = 0; squelchReq = 0;
    cyc = 1;
    chk(busy == 1'b1, "R6 busy after accept", 32'(busy), 32'd1);
    if (le > 0 && clr)
      chk(ctlWord == 32'h0, "R5 cleared before first bit", ctlWord, 32'h0);
    else if (le > 0)
      chk(ctlWord == expWord, "R2 word preserved at start", ctlWord, expWord);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 3) begin
        startReq = 1; reqAddr = ~a; reqData = ~d; reqPort = 2'(port + 1);
      end
      if (inject && cyc == 4) startReq = 0;
    end
    #1;
    chk(cyc == expCyc, "R4 done cycle", 32'(cyc), 32'(expCyc));
    chk(pulseCnt == le, "R3 strobe pulse count", 32'(pulseCnt), 32'(le));
    chk(capVal == (ed & mask), "R3 captured value LSB first", 32'(capVal),
        32'(ed & mask));
    chk(!addrBad, "R3 address sequence", 32'(addrBad), 32'd0);
    chk(!orderBad, "R4 fields set before strobe", 32'(orderBad), 32'd0);
    chk(!widthBad, "R4 strobe high width", 32'(widthBad), 32'd0);
    chk(!strayBad, "R9 other port strobe", 32'(strayBad), 32'd0);
    if (le > 0) begin
      if (clr) expWord = 32'h0;
      expWord[15:8] = 8'(ea + 8'(le - 1));
      expWord[7] = ed[le-1];
    end
    chk(ctlWord == expWord, "R2 final word", ctlWord, expWord);
    @(negedge clk);
    chk(!busy && !done, "R6 idle after done", {busy, done}, 32'd0);
  endtask

  // {addr, data, len, port, clear, hold}
  localparam logic [26:0] VEC [8] = '{
    {8'h20, 8'h14, 4'd5,  2'd0, 1'b0, 4'd1},
    {8'h2A, 8'h03, 4'd2,  2'd1, 1'b1, 4'd2},
    {8'h0C, 8'h01, 4'd1,  2'd0, 1'b0, 4'd3},
    {8'hFE, 8'hA5, 4'd8,  2'd3, 1'b0, 4'd1},
    {8'h10, 8'h3C, 4'd6,  2'd2, 1'b1, 4'd0},
    {8'h40, 8'hFF, 4'd4,  2'd1, 1'b0, 4'd2},
    {8'h33, 8'h5A, 4'd7,  2'd3, 1'b1, 4'd1},
    {8'h77, 8'h81, 4'd12, 2'd2, 1'b0, 4'd1}
  };

  initial begin
    monPort = 0; monHold = 1; monBase = 0; pulseCnt = 0; hiRun = 0; capVal = 0;
    orderBad = 0; addrBad = 0; widthBad = 0; strayBad = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1 reset flags", {busy, done}, 32'd0);
    chk(ctlWord == 32'h5A00_0022, "R1 reset word", ctlWord, 32'h5A00_0022);
    rstN = 1;
    @(negedge clk);
    // R7: zero length before anything else, word untouched
    runWrite(8'h55, 8'hFF, 0, 1, 1'b1, 2, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      runWrite(VEC[i][26:19], VEC[i][18:11], int'(VEC[i][10:7]), int'(VEC[i][6:5]),
               VEC[i][4], int'(VEC[i][3:0]), 0, 0, 0, 0);
    end
    // R8: squelch enable then disable
    runWrite(8'h00, 8'h00, 0, 2, 1'b0, 1, 1, 1, 0, 0);
    runWrite(8'h00, 8'h00, 0, 0, 1'b0, 2, 1, 0, 0, 0);
    // R8: start wins over squelch
    runWrite(8'h60, 8'h0B, 4, 1, 1'b0, 1, 0, 0, 1, 0);
    // R6: request while busy ignored
    runWrite(8'h22, 8'h96, 8, 0, 1'b0, 2, 0, 0, 0, 1);
    // R7: zero length after writes leaves word as is
    runWrite(8'h99, 8'h00, 0, 3, 1'b1, 1, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule